// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

This block watches twenty input lines and turns chosen signal edges into interrupt requests and event pulses. Sixteen lines are numbered by pin position. Each of these lines takes its signal from pin x of one of four 16-bit GPIO ports, and a 4-bit selector code picks the port. The other four lines come directly from internal sources that are already synchronous to the clock. Pin inputs pass through a two-flop synchroniser before edge detection.

Every line has its own rising-edge enable and falling-edge enable, an interrupt mask, an event mask, a software trigger bit and a sticky pending flag. Software clears the pending flag by writing 1 to it. A write that changes the line's edge configuration also clears it. The interrupt request of a line is its pending flag gated by the interrupt mask. The event output is a one-clock pulse for each trigger, gated by the event mask. A plain synchronous register port (write strobe, address, write data, combinational read data) holds all the configuration.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `evt` are all low.
- R2: Selector register k (address k, k = 0..3) holds the 4-bit code for line 4k+j at bits 4j+3:4j. Code 0, 1, 2 or 3 connects line x to `gpio_in[16*code + x]` (ports A, B, C, D). Any other code ties the line to 0.
- R3: Lines 16 to 19 are driven by `int_src[0..3]` with no synchroniser. A qualifying edge on one of them sets pending at the next rising clock edge.
- R4: Rise-enable (address 6) lets a rising edge trigger the line, and fall-enable (address 7) does the same for a falling edge. With both bits set, either edge triggers. With neither set, no edge triggers.
- R5: A pin edge becomes visible in pending, `irq` and `evt` at the third rising clock edge after the pin changes.
- R6: Writing 1 to a pending bit (address 9) clears it and also clears that line's software trigger bit. Writing 0 has no effect.
- R7: A write to address 6 or 7 that changes a line's bit clears that line's pending flag. A bit written with its old value leaves pending unchanged.
- R8: Writing 1 to a software trigger bit (address 8) sets pending only when that bit is currently 0. The bit then stays 1 until pending is cleared by a write of 1.
- R9: `irq[i]` equals pending[i] AND interrupt-mask[i] (address 4).
- R10: Each trigger, from an edge or from software, gives a one-cycle `evt[i]` pulse at the same clock edge that sets pending, when event-mask[i] (address 5) is 1. The pulse does not depend on whether the line was already pending.
- R11: When a trigger and a write-1 clear hit the same line in the same cycle, the line ends up pending.
- R12: Reads are combinational from `reg_addr`. Selector registers return 16 bits, per-line registers return bits 19:0, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 64 | Four 16-bit ports, port p at bits 16p+15:16p |
| int_src | input | 4 | Synchronous internal sources for lines 16 to 19 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 20 | Per-line interrupt request |
| evt | output | 20 | Per-line one-cycle event pulse |

## Verification
A register write takes effect at the clock edge that samples it, so the bench reads results back at the next falling edge. A software trigger raises pending and `evt` at that same edge, and so does an internal-line edge. A pin edge needs three rising edges: two synchroniser stages and then the pending register. The bench waits exactly that long before it samples, checks `evt` once more one cycle later to confirm the pulse has ended, and does every sampling on the falling clock edge.

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
  parameter int PIN_LINES = 16,
  parameter int EXT_LINES = 4,
  parameter int PORTS     = 4,
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PORTS*PIN_LINES-1:0]    gpio_in,
  input  logic [EXT_LINES-1:0]          int_src,
  input  logic                          reg_wr,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic [PIN_LINES+EXT_LINES-1:0] irq,
  output logic [PIN_LINES+EXT_LINES-1:0] evt
);
  localparam int NL      = PIN_LINES + EXT_LINES;
  localparam int FPR     = 4;
  localparam int NSEL    = PIN_LINES / FPR;
  localparam int A_IMASK = NSEL;
  localparam int A_EMASK = NSEL + 1;
  localparam int A_RISE  = NSEL + 2;
  localparam int A_FALL  = NSEL + 3;
  localparam int A_SW    = NSEL + 4;
  localparam int A_PEND  = NSEL + 5;

  logic [SEL_W-1:0] sel_q [PIN_LINES];
  logic [PORTS*PIN_LINES-1:0] s1_q, s2_q;
  logic [NL-1:0] imask_q, emask_q, rise_q, fall_q, sw_q, pend_q, line_q, evt_q;
  logic [NL-1:0] line_now, trig, set, clr, wd;

  assign wd = reg_wdata[NL-1:0];
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DATA_W-1:NL];

  wire wr_imask = reg_wr && reg_addr == ADDR_W'(A_IMASK);
  wire wr_emask = reg_wr && reg_addr == ADDR_W'(A_EMASK);
  wire wr_rise  = reg_wr && reg_addr == ADDR_W'(A_RISE);
  wire wr_fall  = reg_wr && reg_addr == ADDR_W'(A_FALL);
  wire wr_sw    = reg_wr && reg_addr == ADDR_W'(A_SW);
  wire wr_pend  = reg_wr && reg_addr == ADDR_W'(A_PEND);

  always_comb begin
    line_now = '0;
    for (int i = 0; i < PIN_LINES; i++)
      for (int p = 0; p < PORTS; p++)
        if (sel_q[i] == SEL_W'(p)) line_now[i] = s2_q[p*PIN_LINES + i];
    line_now[PIN_LINES +: EXT_LINES] = int_src;
  end

  assign trig = (rise_q & line_now & ~line_q) | (fall_q & ~line_now & line_q);
  assign set  = trig | (wr_sw ? (wd & ~sw_q) : '0);
  assign clr  = (wr_pend ? wd : '0) | (wr_rise ? (wd ^ rise_q) : '0)
              | (wr_fall ? (wd ^ fall_q) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PIN_LINES; i++) sel_q[i] <= '0;
      s1_q <= '0; s2_q <= '0;
      imask_q <= '0; emask_q <= '0; rise_q <= '0; fall_q <= '0;
      sw_q <= '0; pend_q <= '0; line_q <= '0; evt_q <= '0;
    end else begin
      for (int i = 0; i < PIN_LINES; i++)
        if (reg_wr && reg_addr == ADDR_W'(i / FPR))
          sel_q[i] <= reg_wdata[(i % FPR)*SEL_W +: SEL_W];
      s1_q   <= gpio_in;
      s2_q   <= s1_q;
      line_q <= line_now;
      if (wr_imask) imask_q <= wd;
      if (wr_emask) emask_q <= wd;
      if (wr_rise)  rise_q  <= wd;
      if (wr_fall)  fall_q  <= wd;
      if (wr_sw)    sw_q    <= sw_q | wd;
      else if (wr_pend) sw_q <= sw_q & ~wd;
      pend_q <= (pend_q & ~clr) | set;
      evt_q  <= set & emask_q;
    end
  end

  assign irq = pend_q & imask_q;
  assign evt = evt_q;

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < PIN_LINES; i++)
      if (reg_addr == ADDR_W'(i / FPR))
        reg_rdata[(i % FPR)*SEL_W +: SEL_W] = sel_q[i];
    case (reg_addr)
      ADDR_W'(A_IMASK): reg_rdata = DATA_W'(imask_q);
      ADDR_W'(A_EMASK): reg_rdata = DATA_W'(emask_q);
      ADDR_W'(A_RISE):  reg_rdata = DATA_W'(rise_q);
      ADDR_W'(A_FALL):  reg_rdata = DATA_W'(fall_q);
      ADDR_W'(A_SW):    reg_rdata = DATA_W'(sw_q);
      ADDR_W'(A_PEND):  reg_rdata = DATA_W'(pend_q);
      default: ;
    endcase
  end
endmodule

module edge_irq_ctrl_chk #(
  parameter int NL = 20, parameter int ADDR_W = 4, parameter int DATA_W = 32,
  parameter int A_PEND = 9, parameter int A_RISE = 6
) (
  input logic clk, input logic rst_n, input logic reg_wr,
  input logic [ADDR_W-1:0] reg_addr, input logic [DATA_W-1:0] reg_wdata,
  input logic [NL-1:0] pend, input logic [NL-1:0] set, input logic [NL-1:0] rise,
  input logic [NL-1:0] imask, input logic [NL-1:0] emask,
  input logic [NL-1:0] irq, input logic [NL-1:0] evt
);
  a_r6_write1_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(A_PEND)) |=>
      ((pend & $past(reg_wdata[NL-1:0]) & ~$past(set)) == '0));
  a_r7_cfg_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(A_RISE)) |=>
      ((pend & ($past(reg_wdata[NL-1:0]) ^ $past(rise)) & ~$past(set)) == '0));
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((pend & $past(set)) == $past(set)));
  a_r10_evt_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~$past(emask)) == '0);
  a_r9_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (imask == '0) |-> (irq == '0));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(
  .NL(PIN_LINES + EXT_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .A_PEND(A_PEND), .A_RISE(A_RISE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pend(pend_q), .set(set), .rise(rise_q),
  .imask(imask_q), .emask(emask_q), .irq(irq), .evt(evt)
);

// File: tb/edge_irq_ctrl_bench.sv
module edge_irq_ctrl_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [63:0] gpio_in = '0;
  logic [3:0]  int_src = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [19:0] irq, evt;
  int errors = 0, checks = 0;
  bit done = 0;

  edge_irq_ctrl u_edge_irq_ctrl (.clk, .rst_n, .gpio_in, .int_src, .reg_wr,
    .reg_addr, .reg_wdata, .reg_rdata, .irq, .evt);

  localparam logic [31:0] ALL = 32'h000F_FFFF;

  // {line[10:6], port[5:4], rise[3], fall[2], dir[1] (1=rising), expect[0]}
  localparam logic [10:0] VEC [8] = '{
    {5'd3,  2'd0, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd5,  2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd10, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd15, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1},
    {5'd0,  2'd3, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd7,  2'd1, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd12, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'd9,  2'd2, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1 irq after reset", 32'(irq), 0);
    check("R1 evt after reset", 32'(evt), 0);
    rd(9, d); check("R1 pending after reset", d, 0);
    rd(0, d); check("R1 selector after reset", d, 0);
    rst_n = 1'b1;

    for (int k = 0; k < 8; k++) begin
      int ln, pt; logic r, f, dir, ex;
      ln = int'(VEC[k][10:6]); pt = int'(VEC[k][5:4]);
      r = VEC[k][3]; f = VEC[k][2]; dir = VEC[k][1]; ex = VEC[k][0];
      gpio_in = '0;
      wr(4'(ln / 4), 32'(pt) << (4 * (ln % 4)));
      wr(6, 32'(r) << ln); wr(7, 32'(f) << ln);
      wr(4, ALL); wr(5, ALL);
      @(negedge clk); gpio_in[pt*16 + ln] = ~dir;
      repeat (4) @(negedge clk);
      wr(9, ALL);
      rd(9, d); check("R6 pending cleared before edge", d, 0);
      @(negedge clk); gpio_in[pt*16 + ln] = dir;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R4 R5 R2 irq after pin edge", 32'(irq[ln]), 32'(ex));
      check("R10 evt pulse on pin edge", 32'(evt[ln]), 32'(ex));
      @(negedge clk);
      check("R10 evt lasts one cycle", 32'(evt[ln]), 0);
      gpio_in = '0;
      repeat (4) @(negedge clk);
      wr(9, ALL);
    end

    // R12 readback
    wr(0, 32'hFFFF_A5C3); rd(0, d); check("R12 selector readback", d, 32'h0000_A5C3);
    wr(4, 32'hFFFF_FFFF); rd(4, d); check("R12 mask readback width", d, ALL);

    // R2 invalid code
    wr(0, 32'h0000_0050); wr(6, 32'h2); wr(7, 0); wr(9, ALL);
    @(negedge clk); gpio_in = 64'h0002_0002_0002_0002;
    repeat (3) @(posedge clk); @(negedge clk);
    check("R2 invalid selector ties line low", 32'(irq[1]), 0);
    gpio_in = '0; repeat (4) @(negedge clk);

    // R2 wrong port ignored
    wr(1, 0); wr(6, 32'h10); wr(9, ALL);
    @(negedge clk); gpio_in[16 + 4] = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    check("R2 unselected port has no effect", 32'(irq[4]), 0);
    gpio_in = '0; repeat (4) @(negedge clk); wr(9, ALL);

    // R3 internal line
    wr(6, 32'(1) << 17); wr(9, ALL);
    @(negedge clk); int_src[1] = 1'b1;
    @(negedge clk);
    check("R3 internal line pending after one edge", 32'(irq[17]), 1);
    check("R3 internal line event", 32'(evt[17]), 1);
    int_src = '0; wr(9, ALL);

    // R11 set beats clear
    wr(6, 32'(1) << 18); wr(9, ALL);
    @(negedge clk); int_src[2] = 1'b1; reg_wr = 1'b1; reg_addr = 9; reg_wdata = ALL;
    @(negedge clk); reg_wr = 1'b0;
    rd(9, d); check("R11 trigger wins over clear", d, 32'(1) << 18);
    int_src = '0; wr(6, 0); wr(9, ALL);

    // R8 R9 R10 R6 software trigger
    wr(4, 32'h4); wr(5, 32'h4);
    wr(8, 32'h4);
    check("R8 software set raises irq", 32'(irq[2]), 1);
    check("R10 software set gives event", 32'(evt[2]), 1);
    rd(8, d); check("R8 software bit reads 1", d, 32'h4);
    @(negedge clk); check("R10 software event one cycle", 32'(evt[2]), 0);
    wr(4, 0);
    check("R9 mask blocks irq", 32'(irq[2]), 0);
    rd(9, d); check("R9 pending held while masked", d, 32'h4);
    wr(9, 0); rd(9, d); check("R6 write 0 no effect", d, 32'h4);
    wr(9, 32'h4); rd(9, d); check("R6 write 1 clears pending", d, 0);
    rd(8, d); check("R6 clear also drops software bit", d, 0);

    // R7 / R8 only when bit is 0
    wr(8, 32'h4); wr(6, 32'h4);
    rd(9, d); check("R7 rise change clears pending", d, 0);
    rd(8, d); check("R8 software bit stays set", d, 32'h4);
    wr(8, 32'h4); rd(9, d); check("R8 no set when bit already 1", d, 0);
    wr(9, ALL);

    wr(8, 32'h100); wr(6, 32'h4);
    rd(9, d); check("R7 unchanged rise keeps pending", d, 32'h100);
    wr(7, 32'h100); rd(9, d); check("R7 fall change clears pending", d, 0);

    // R10 event mask gating
    wr(5, 0); wr(4, ALL); wr(9, ALL);
    wr(8, 32'h800);
    check("R10 event masked", 32'(evt), 0);
    check("R9 irq with mask open", 32'(irq[11]), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule